// File: doc/BRIEF.md
# SMBus Control Register and Receive-Acknowledge Unit

This block holds the byte-wide control register of a multi-master I2C/SMBus controller and decides the acknowledge level driven in the ninth clock of each received byte. Software reaches the register through a simple read/write port with an address select. The register's bits enable the controller, gate its interrupt, request a repeated START, suppress acknowledges, pulse a clear of the bus-busy flag, and mark the next received byte as the packet error check (PEC) byte.

Bit-level SCL/SDA sequencing, START/STOP detection, arbitration and address matching live elsewhere. They reach this block as single-cycle strobes: a START seen, a byte finished (with its data and direction), master mode, and repeated-START completion. Over every byte since the last START, the block keeps a running CRC-8 (polynomial x^8+x^2+x+1, seed 0, MSB first). When a PEC byte arrives in slave receive with a nonzero remainder, the block forces a NAK. In every other case the acknowledge follows the software no-acknowledge bit.

Top module: `pecAckCtrl`

## Requirements
- R1: After reset every control bit is 0. The control register reads 0x00, and irq, busyClr, rsReq, ackValid and ackDrive are 0 while flagReset is 1.
- R2: Reads and writes at address CTRL_ADDR (default 0) reach the control register. Its bit positions are: enable bit 7, interrupt enable bit 6, clear-busy bit 5, acknowledge disable bit 3, repeated-START enable bit 2, PEC-byte bit 1. Bits 5, 4 and 0 always read 0. Any other address reads 0x00, and a write to it changes nothing.
- R3: flagReset is 1 exactly while the enable bit is 0, which returns the status flags to their defaults.
- R4: irq is 1 only when enable and interrupt enable are both 1 and at least one bit of statFlags is 1. The bits of statFlags are: bit 0 transmit, bit 1 receive, bit 2 arbitration lost, bit 3 NAK.
- R5: A register write with bit 5 = 1 gives a one-cycle busyClr pulse in the cycle after the write. A write with bit 5 = 0 gives no pulse.
- R6: rsReq equals repeated-START enable AND masterMode AND enable. The hardware clears the repeated-START enable bit on the cycle after rsDone, or after masterMode falls from 1 to 0. This clear takes priority over a software write in the same cycle.
- R7: The running CRC-8 uses polynomial 0x07, seed 0 and MSB first. It covers every byte strobed with byteStb (either direction) since the last busStart, and busStart returns it to 0.
- R8: A received byte (byteStb with byteIsRx = 1 while enabled) gives a one-cycle ackValid pulse in the next cycle. With that pulse, ackDrive is 1 (ACK) when the acknowledge-disable bit is 0. Outside an ackValid pulse, ackDrive is 0.
- R9: In slave receive (isSlave = 1) with the PEC-byte bit set, ackDrive is 0 when the CRC remainder after that byte is nonzero. When the remainder is zero, ackDrive follows the acknowledge-disable bit.
- R10: In master receive (isSlave = 0) with the PEC-byte bit set, ackDrive follows the acknowledge-disable bit whatever the CRC result.
- R11: The PEC-byte bit clears itself on the cycle after the received byte it marked.
- R12: While enable is 0, byte strobes give no ackValid and the CRC is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | ADDR_W | Register address select |
| cpuWr | input | 1 | Write strobe |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data (combinational) |
| statFlags | input | FLAG_N | Status flags: tx, rx, arb lost, NAK |
| irq | output | 1 | Interrupt request |
| flagReset | output | 1 | Forces status flags to defaults |
| busyClr | output | 1 | One-cycle bus-busy clear pulse |
| masterMode | input | 1 | Controller is bus master |
| rsDone | input | 1 | Repeated START completed |
| rsReq | output | 1 | Repeated START request |
| busStart | input | 1 | START or repeated START seen |
| byteStb | input | 1 | A byte finished its eighth bit |
| byteIsRx | input | 1 | That byte was received |
| isSlave | input | 1 | Transfer is slave receive |
| byteData | input | 8 | Byte value |
| ackValid | output | 1 | Acknowledge decision valid |
| ackDrive | output | 1 | 1 = ACK, 0 = NAK |

## Verification
The assertions assume that byteStb, busStart and rsDone are single-cycle strobes, and that busStart never shares a cycle with byteStb. They also assume that inputs are driven during reset to their idle values, so any look one cycle back after reset sees quiet strobes. The stimulus keeps to these rules. Every strobe is raised for one tick and dropped before the next tick, a START always stands on its own cycle, and every input is held at 0 for the whole reset period. Under these rules the reference model's view of the CRC, which moves one byte per strobe, stays in step with the design's.

// File: rtl/pecAckPkg.sv
package pecAckPkg;
  localparam int BYTE_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int IE_BIT   = 6;
  localparam int CLRB_BIT = 5;
  localparam int NOAK_BIT = 3;
  localparam int RS_BIT   = 2;
  localparam int PEC_BIT  = 1;

  // control -> datapath
  typedef struct packed {
    logic enable;
    logic ackDisable;
    logic pecMode;
  } ctrlToDp_t;

  // datapath -> control
  typedef struct packed {
    logic pecTaken;
  } dpToCtrl_t;

  function automatic logic [BYTE_W-1:0] crcStep(input logic [BYTE_W-1:0] crcIn,
                                                input logic [BYTE_W-1:0] dataIn,
                                                input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] acc;
    logic fb;
    acc = crcIn;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb  = acc[BYTE_W-1] ^ dataIn[i];
      acc = {acc[BYTE_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/pecCtrl.sv
module pecCtrl
  import pecAckPkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int FLAG_N    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic [BYTE_W-1:0] cpuWrData,
  output logic [BYTE_W-1:0] cpuRdData,
  input  logic [FLAG_N-1:0] statFlags,
  input  logic              masterMode,
  input  logic              rsDone,
  input  dpToCtrl_t         dpIn,
  output ctrlToDp_t         ctrlOut,
  output logic              irq,
  output logic              flagReset,
  output logic              busyClr,
  output logic              rsReq
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

  logic enQ, ieQ, noAckQ, rsEnQ, pecQ, masterQ, busyClrQ;
  logic regSel, regWr, masterFell, rsClr;
  logic unusedWrBits;

  assign regSel       = (cpuAddr == SEL);
  assign regWr        = cpuWr && regSel;
  assign masterFell   = masterQ && !masterMode;
  assign rsClr        = rsDone || masterFell;
  assign unusedWrBits = ^{cpuWrData[4], cpuWrData[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      ieQ      <= 1'b0;
      noAckQ   <= 1'b0;
      rsEnQ    <= 1'b0;
      pecQ     <= 1'b0;
      masterQ  <= 1'b0;
      busyClrQ <= 1'b0;
    end else begin
      masterQ  <= masterMode;
      busyClrQ <= regWr && cpuWrData[CLRB_BIT];
      if (regWr) begin
        enQ    <= cpuWrData[EN_BIT];
        ieQ    <= cpuWrData[IE_BIT];
        noAckQ <= cpuWrData[NOAK_BIT];
      end
      if (rsClr)      rsEnQ <= 1'b0;
      else if (regWr) rsEnQ <= cpuWrData[RS_BIT];
      if (dpIn.pecTaken) pecQ <= 1'b0;
      else if (regWr)    pecQ <= cpuWrData[PEC_BIT];
    end
  end

  always_comb begin
    cpuRdData = '0;
    if (regSel) begin
      cpuRdData[EN_BIT]   = enQ;
      cpuRdData[IE_BIT]   = ieQ;
      cpuRdData[NOAK_BIT] = noAckQ;
      cpuRdData[RS_BIT]   = rsEnQ;
      cpuRdData[PEC_BIT]  = pecQ;
    end
  end

  assign ctrlOut.enable     = enQ;
  assign ctrlOut.ackDisable = noAckQ;
  assign ctrlOut.pecMode    = pecQ;

  assign irq       = enQ && ieQ && (|statFlags);
  assign flagReset = !enQ;
  assign busyClr   = busyClrQ;
  assign rsReq     = rsEnQ && masterMode && enQ;
endmodule

// File: rtl/pecDatapath.sv
module pecDatapath
  import pecAckPkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlToDp_t         ctrlIn,
  output dpToCtrl_t         dpOut,
  input  logic              busStart,
  input  logic              byteStb,
  input  logic              byteIsRx,
  input  logic              isSlave,
  input  logic [BYTE_W-1:0] byteData,
  output logic              ackValid,
  output logic              ackDrive
);
  logic [BYTE_W-1:0] crcQ, crcNext;
  logic rxTake, pecFail, ackValidQ, ackDriveQ;

  assign crcNext = crcStep(crcQ, byteData, CRC_POLY);
  assign rxTake  = ctrlIn.enable && byteStb && byteIsRx;
  assign pecFail = ctrlIn.pecMode && isSlave && (crcNext != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ      <= '0;
      ackValidQ <= 1'b0;
      ackDriveQ <= 1'b0;
    end else begin
      if (!ctrlIn.enable || busStart) crcQ <= '0;
      else if (byteStb)               crcQ <= crcNext;
      ackValidQ <= rxTake;
      ackDriveQ <= rxTake && !ctrlIn.ackDisable && !pecFail;
    end
  end

  assign dpOut.pecTaken = rxTake && ctrlIn.pecMode;
  assign ackValid       = ackValidQ;
  assign ackDrive       = ackDriveQ;
endmodule

// File: rtl/pecAckCtrl.sv
module pecAckCtrl
  import pecAckPkg::*;
#(
  parameter int         ADDR_W    = 2,
  parameter int         CTRL_ADDR = 0,
  parameter int         FLAG_N    = 4,
  parameter logic [7:0] CRC_POLY  = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  input  logic [FLAG_N-1:0] statFlags,
  output logic              irq,
  output logic              flagReset,
  output logic              busyClr,
  input  logic              masterMode,
  input  logic              rsDone,
  output logic              rsReq,
  input  logic              busStart,
  input  logic              byteStb,
  input  logic              byteIsRx,
  input  logic              isSlave,
  input  logic [7:0]        byteData,
  output logic              ackValid,
  output logic              ackDrive
);
  ctrlToDp_t c2d;
  dpToCtrl_t d2c;

  pecCtrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_N(FLAG_N)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .statFlags(statFlags),
    .masterMode(masterMode), .rsDone(rsDone), .dpIn(d2c), .ctrlOut(c2d),
    .irq(irq), .flagReset(flagReset), .busyClr(busyClr), .rsReq(rsReq)
  );

  pecDatapath #(.CRC_POLY(CRC_POLY)) uDp (
    .clk(clk), .rstN(rstN), .ctrlIn(c2d), .dpOut(d2c), .busStart(busStart),
    .byteStb(byteStb), .byteIsRx(byteIsRx), .isSlave(isSlave),
    .byteData(byteData), .ackValid(ackValid), .ackDrive(ackDrive)
  );
endmodule

// File: rtl/pecAckCtrlChk.sv
module pecAckCtrlChk #(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int FLAG_N    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWr,
  input logic [7:0]        cpuWrData,
  input logic [7:0]        cpuRdData,
  input logic [FLAG_N-1:0] statFlags,
  input logic              irq,
  input logic              flagReset,
  input logic              busyClr,
  input logic              masterMode,
  input logic              rsReq,
  input logic              byteStb,
  input logic              byteIsRx,
  input logic              ackValid,
  input logic              ackDrive
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

  // R5
  busy_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyClr |-> $past(cpuWr && cpuAddr == SEL && cpuWrData[5]));

  // R5
  busy_pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyClr |=> !busyClr || $past(cpuWr && cpuAddr == SEL && cpuWrData[5]));

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|statFlags));

  // R3
  irq_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagReset |-> !irq && !rsReq);

  // R6
  rs_needs_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsReq |-> masterMode);

  // R6
  rs_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsReq && cpuAddr == SEL) |-> cpuRdData[2]);

  // R8
  ack_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteStb && byteIsRx && !flagReset));

  // R8
  ack_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> ackValid);
endmodule

bind pecAckCtrl pecAckCtrlChk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_N(FLAG_N)) uChk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuWrData(cpuWrData),
  .cpuRdData(cpuRdData), .statFlags(statFlags), .irq(irq), .flagReset(flagReset),
  .busyClr(busyClr), .masterMode(masterMode), .rsReq(rsReq), .byteStb(byteStb),
  .byteIsRx(byteIsRx), .ackValid(ackValid), .ackDrive(ackDrive)
);

// File: tb/test_pecAckCtrl.sv
`timescale 1ns/1ps
module test_pecAckCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic cpuWr = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic [3:0] statFlags = '0;
  logic irq, flagReset, busyClr, rsReq, ackValid, ackDrive;
  logic masterMode = 1'b0, rsDone = 1'b0, busStart = 1'b0;
  logic byteStb = 1'b0, byteIsRx = 1'b0, isSlave = 1'b0;
  logic [7:0] byteData = '0;

  always #5 clk = ~clk;

  pecAckCtrl i_pecAckCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .statFlags(statFlags), .irq(irq), .flagReset(flagReset),
    .busyClr(busyClr), .masterMode(masterMode), .rsDone(rsDone), .rsReq(rsReq),
    .busStart(busStart), .byteStb(byteStb), .byteIsRx(byteIsRx), .isSlave(isSlave),
    .byteData(byteData), .ackValid(ackValid), .ackDrive(ackDrive)
  );

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mEn, mIe, mNoAck, mRs, mPec, mMasterQ, mBusy, mAckV, mAckD;
  int mCrc;
  byte unsigned sent[$];

  function automatic int crc8(input int c, input int d);
    int r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (((r >> 7) & 1) != ((d >> i) & 1)) r = ((r << 1) ^ 7) & 255;
      else r = (r << 1) & 255;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mIe = 0; mNoAck = 0; mRs = 0; mPec = 0;
      mMasterQ = 0; mBusy = 0; mAckV = 0; mAckD = 0; mCrc = 0;
    end else begin
      bit wr, take, fail, oldPec;
      int nxt;
      wr = cpuWr && cpuAddr == 0;
      nxt = crc8(mCrc, byteData);
      take = mEn && byteStb && byteIsRx;
      fail = mPec && isSlave && nxt != 0;
      oldPec = mPec;
      mAckV = take;
      mAckD = take && !mNoAck && !fail;
      mBusy = wr && cpuWrData[5];
      if (!mEn || busStart) mCrc = 0;
      else if (byteStb) mCrc = nxt;
      if (wr) begin
        mEn = cpuWrData[7]; mIe = cpuWrData[6]; mNoAck = cpuWrData[3];
        mRs = cpuWrData[2]; mPec = cpuWrData[1];
      end
      if (rsDone || (mMasterQ && !masterMode)) mRs = 0;
      if (take && oldPec) mPec = 0;
      mMasterQ = masterMode;
    end
  end

  task automatic cmp(input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", curReq, what, got, exp);
    end
  endtask

  task automatic compareAll();
    int expRd;
    expRd = (cpuAddr == 0) ? ((mEn << 7) | (mIe << 6) | (mNoAck << 3) | (mRs << 2) | (mPec << 1)) : 0;
    cmp("cpuRdData", cpuRdData, expRd);
    cmp("irq", irq, mEn && mIe && (statFlags != 0));
    cmp("flagReset", flagReset, !mEn);
    cmp("busyClr", busyClr, mBusy);
    cmp("rsReq", rsReq, mRs && masterMode && mEn);
    cmp("ackValid", ackValid, mAckV);
    cmp("ackDrive", ackDrive, mAckD);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wrReg(input logic [7:0] d, input logic [1:0] a = 2'd0);
    cpuAddr = a; cpuWr = 1'b1; cpuWrData = d;
    tick();
    cpuWr = 1'b0; cpuAddr = 2'd0;
  endtask

  task automatic start();
    busStart = 1'b1; tick(); busStart = 1'b0;
    sent.delete();
  endtask

  task automatic sendByte(input logic [7:0] d, input logic rx);
    byteStb = 1'b1; byteIsRx = rx; byteData = d;
    tick();
    byteStb = 1'b0; byteIsRx = 1'b0;
    sent.push_back(d);
  endtask

  function automatic logic [7:0] goodPec();
    int c;
    c = 0;
    foreach (sent[i]) c = crc8(c, sent[i]);
    return c[7:0];
  endfunction

  bit finished = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    tick();
    rstN = 1'b1;
    tick(); tick();

    // register map and readback
    curReq = "R2";
    wrReg(8'hFF);
    tick();
    wrReg(8'h00, 2'd1);
    cpuAddr = 2'd1; tick(); cpuAddr = 2'd0;
    tick();
    wrReg(8'h4A);
    tick();

    curReq = "R3";
    wrReg(8'h00); tick();
    wrReg(8'h80); tick();

    curReq = "R4";
    wrReg(8'hC0);
    for (int i = 0; i < 4; i++) begin
      statFlags = 4'(1 << i); tick();
    end
    statFlags = 4'b1010; tick();
    statFlags = 4'b0000; tick();
    statFlags = 4'b0100; wrReg(8'h80); tick();
    wrReg(8'h40); tick();
    statFlags = 4'b0000;

    curReq = "R5";
    wrReg(8'hA0); tick();
    wrReg(8'h80); tick();

    curReq = "R6";
    masterMode = 1'b1; tick();
    wrReg(8'h84); tick();
    rsDone = 1'b1; tick(); rsDone = 1'b0; tick();
    wrReg(8'h84); tick();
    masterMode = 1'b0; tick(); tick();
    wrReg(8'h84); tick();
    masterMode = 1'b1; tick();
    masterMode = 1'b0; wrReg(8'h84); tick();

    // slave receive, correct PEC
    curReq = "R7";
    wrReg(8'h80);
    isSlave = 1'b1;
    start();
    sendByte(8'hA6, 1'b1);
    curReq = "R8";
    sendByte(8'h3C, 1'b1);
    sendByte(8'h11, 1'b0);
    sendByte(8'hF0, 1'b1);
    tick();
    curReq = "R9";
    wrReg(8'h82);
    sendByte(goodPec(), 1'b1);
    curReq = "R11";
    tick();

    // slave receive, bad PEC
    curReq = "R9";
    start();
    sendByte(8'h55, 1'b1);
    sendByte(8'h01, 1'b1);
    wrReg(8'h82);
    sendByte(goodPec() ^ 8'h40, 1'b1);
    tick();

    // ack disabled
    curReq = "R8";
    wrReg(8'h88);
    start();
    sendByte(8'h77, 1'b1);
    wrReg(8'h8A);
    sendByte(goodPec(), 1'b1);
    tick();

    // master receive, bad PEC still acks
    curReq = "R10";
    wrReg(8'h80);
    isSlave = 1'b0;
    start();
    sendByte(8'h9B, 1'b0);
    sendByte(8'h2E, 1'b1);
    wrReg(8'h82);
    sendByte(goodPec() ^ 8'h01, 1'b1);
    tick();

    // disabled: no ack, CRC cleared
    curReq = "R12";
    isSlave = 1'b1;
    start();
    sendByte(8'hC3, 1'b1);
    wrReg(8'h00);
    sendByte(8'h5A, 1'b1);
    tick();
    wrReg(8'h82);
    sendByte(8'h00, 1'b1);
    tick(); tick();

    finished = 1;
    summary();
    $finish;
  end
endmodule